// File: doc/BRIEF.md
# Remapping Byte Queue

This block is a first-in first-out queue of byte values that can be corrected after the values have been queued. A separate command port gives it value substitutions of the form "value A now stands for value B". The block does not rewrite the stored entries. Instead it keeps one remap record per possible byte value, and each popped byte is passed through that table. The lookup repeats on each result until it reaches a value that has no mapping. Each lookup takes one clock. The pop result therefore arrives one cycle after the pop is accepted, plus one cycle for each mapping followed.

Many source values may point at the same target, so the table is indexed by source value only and keeps no reverse links. A walk is capped at a fixed number of hops. If a mapping still exists when the cap is reached, the block returns the value it has reached and raises an error flag. While a walk is in progress, the block accepts neither new pops nor new substitution commands. Every walk therefore sees one unchanging table. A producer that sends commands faster than reads drain them is paused through the command-ready signal.

Top module: `remap_fifo`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), `pop_valid`=0, `pop_ready`=1 and `chg_ready`=1, and no value has a mapping.
- R2: Values leave in the order they were pushed. A pop accepted at a clock edge whose value has no mapping gives `pop_valid` high for exactly one cycle, after the next edge, with `pop_data` equal to the pushed value.
- R3: An accepted command (`chg_from`=A, `chg_to`=B, A≠B) makes later pops of A return B. This includes entries that were queued before the command.
- R4: Mappings chain. Each mapping followed adds one cycle, so `pop_valid` rises 1+h edges after the accepting edge when h mappings are followed.
- R5: Several different source values may map to the same target, and each of them resolves to that target.
- R6: A walk follows at most MAX_HOPS (default 8) mappings. With exactly 8 hops `pop_err`=0. If the value reached after 8 hops is itself mapped, the pop completes 9 edges after acceptance with that value and `pop_err`=1 in the `pop_valid` cycle. `pop_err` is never high without `pop_valid`.
- R7: A command whose `chg_from` equals `chg_to` removes the mapping of that value.
- R8: From the edge that accepts a pop until the walk completes, `pop_ready` and `chg_ready` are low. A command presented while `chg_ready` is low has no effect.
- R9: The queue holds DEPTH (default 512) entries. When it is full, `q_full`=1 and a push is dropped. A pop request while the queue is empty produces no `pop_valid`.
- R10: A later command for the same source value replaces its earlier target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push request |
| push_data | input | 8 | Byte to enqueue |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| pop_req | input | 1 | Pop request, taken when `pop_ready` and not empty |
| pop_ready | output | 1 | No walk in progress |
| pop_valid | output | 1 | One-cycle result strobe |
| pop_data | output | 8 | Resolved byte |
| pop_err | output | 1 | Hop cap reached on this result |
| chg_valid | input | 1 | Substitution command present |
| chg_from | input | 8 | Source value of the command |
| chg_to | input | 8 | Target value of the command |
| chg_ready | output | 1 | Command accepted at this edge when valid |

## Verification
The bench builds the block with its default parameters: 8-bit values, 512 entries and a cap of 8 hops. The full depth is small enough that the bench can fill the queue, overflow it and drain it all the way. The 8-bit width allows a chain of nine distinct values and a two-value cycle, which reach the hop cap exactly and go past it. For each pop, the bench measures the latency in edges and compares it with the number of mappings it expects to be followed.

// File: rtl/remap_pkg.sv
package remap_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/remap_store.sv
module remap_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = mem_q[st_q.rp];
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_comb begin
        st_d = st_q;
        if (do_wr) begin
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_rd) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        if (do_wr && !do_rd) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_rd && !do_wr) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[st_q.wp] <= wr_data;
        end
    end
endmodule

// File: rtl/remap_table.sv
module remap_table #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_src,
    input  logic [DATA_W-1:0] wr_dst,
    input  logic [DATA_W-1:0] lk_addr,
    output logic              lk_mapped,
    output logic [DATA_W-1:0] lk_target
);
    localparam int ENTRIES = 1 << DATA_W;

    logic [ENTRIES-1:0] map_d, map_q;
    logic [DATA_W-1:0]  tgt_q [ENTRIES];

    assign lk_mapped = map_q[lk_addr];
    assign lk_target = tgt_q[lk_addr];

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            // a self-substitution clears the record instead of looping
            map_d[wr_src] = (wr_src != wr_dst);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tgt_q[wr_src] <= wr_dst;
        end
    end
endmodule

// File: rtl/remap_resolver.sv
module remap_resolver
    import remap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MAX_HOPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_req,
    input  logic              src_empty,
    input  logic [DATA_W-1:0] src_head,
    output logic              src_pop,
    input  logic              lk_mapped,
    input  logic [DATA_W-1:0] lk_target,
    output logic [DATA_W-1:0] lk_addr,
    output logic              idle,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err
);
    localparam int HW = $clog2(MAX_HOPS + 1);

    typedef struct packed {
        walk_state_e       state;
        logic [DATA_W-1:0] cur;
        logic [HW-1:0]     hops;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              err;
    } walk_t;

    walk_t w_d, w_q;

    assign idle      = (w_q.state == WALK_IDLE);
    assign src_pop   = idle && pop_req && !src_empty;
    assign lk_addr   = w_q.cur;
    assign res_valid = w_q.valid;
    assign res_data  = w_q.data;
    assign res_err   = w_q.err;

    always_comb begin
        w_d       = w_q;
        w_d.valid = 1'b0;
        w_d.err   = 1'b0;
        case (w_q.state)
            WALK_IDLE: begin
                if (src_pop) begin
                    w_d.state = WALK_BUSY;
                    w_d.cur   = src_head;
                    w_d.hops  = '0;
                end
            end
            default: begin
                if (!lk_mapped) begin
                    w_d.state = WALK_IDLE;
                    w_d.valid = 1'b1;
                    w_d.data  = w_q.cur;
                end else if (w_q.hops == HW'(MAX_HOPS)) begin
                    w_d.state = WALK_IDLE;
                    w_d.valid = 1'b1;
                    w_d.err   = 1'b1;
                    w_d.data  = w_q.cur;
                end else begin
                    w_d.cur  = lk_target;
                    w_d.hops = w_q.hops + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{state: WALK_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/remap_fifo.sv
module remap_fifo #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 512,
    parameter int MAX_HOPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    output logic              q_full,
    output logic              q_empty,
    input  logic              pop_req,
    output logic              pop_ready,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_err,
    input  logic              chg_valid,
    input  logic [DATA_W-1:0] chg_from,
    input  logic [DATA_W-1:0] chg_to,
    output logic              chg_ready
);
    logic [DATA_W-1:0] head, lk_addr, lk_target;
    logic              src_pop, lk_mapped, walk_idle;

    assign pop_ready = walk_idle;
    assign chg_ready = walk_idle;

    remap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_en),
        .wr_data (push_data),
        .rd_en   (src_pop),
        .head    (head),
        .full    (q_full),
        .empty   (q_empty)
    );

    remap_table #(.DATA_W(DATA_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (chg_valid && walk_idle),
        .wr_src    (chg_from),
        .wr_dst    (chg_to),
        .lk_addr   (lk_addr),
        .lk_mapped (lk_mapped),
        .lk_target (lk_target)
    );

    remap_resolver #(.DATA_W(DATA_W), .MAX_HOPS(MAX_HOPS)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (pop_req),
        .src_empty (q_empty),
        .src_head  (head),
        .src_pop   (src_pop),
        .lk_mapped (lk_mapped),
        .lk_target (lk_target),
        .lk_addr   (lk_addr),
        .idle      (walk_idle),
        .res_valid (pop_valid),
        .res_data  (pop_data),
        .res_err   (pop_err)
    );
endmodule

// File: rtl/remap_fifo_chk.sv
module remap_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_en,
    input logic              q_full,
    input logic              q_empty,
    input logic              pop_req,
    input logic              pop_ready,
    input logic              pop_valid,
    input logic              pop_err,
    input logic              chg_ready
);
    logic accept;
    assign accept = pop_req && pop_ready && !q_empty;

    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

    a_r6_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pop_err |-> pop_valid);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!pop_ready && !chg_ready));

    a_r9_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    a_r9_full_holds_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && push_en && !accept) |=> q_full);

    a_r1_no_valid_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ready && !accept) |=> !pop_valid);
endmodule

bind remap_fifo remap_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .pop_req   (pop_req),
    .pop_ready (pop_ready),
    .pop_valid (pop_valid),
    .pop_err   (pop_err),
    .chg_ready (chg_ready)
);

// File: tb/test_remap_fifo.sv
module test_remap_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_en = 1'b0;
    logic [7:0] push_data = '0;
    logic       q_full, q_empty;
    logic       pop_req = 1'b0;
    logic       pop_ready, pop_valid, pop_err;
    logic [7:0] pop_data;
    logic       chg_valid = 1'b0;
    logic [7:0] chg_from = '0, chg_to = '0;
    logic       chg_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    remap_fifo i_remap_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_data(push_data),
        .q_full(q_full), .q_empty(q_empty),
        .pop_req(pop_req), .pop_ready(pop_ready),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_err(pop_err),
        .chg_valid(chg_valid), .chg_from(chg_from), .chg_to(chg_to),
        .chg_ready(chg_ready)
    );

    // {from, to, pushed, expected, hops}; applied cumulatively
    localparam logic [39:0] VEC [8] = '{
        {8'd10,  8'd20,  8'd10,  8'd20,  8'd1},  // R3
        {8'd20,  8'd30,  8'd10,  8'd30,  8'd2},  // R4
        {8'd40,  8'd30,  8'd40,  8'd30,  8'd1},  // R5
        {8'd50,  8'd60,  8'd70,  8'd70,  8'd0},  // R2
        {8'd30,  8'd31,  8'd40,  8'd31,  8'd2},  // R5
        {8'd50,  8'd50,  8'd50,  8'd50,  8'd0},  // R7
        {8'd10,  8'd11,  8'd10,  8'd11,  8'd1},  // R10
        {8'hFF,  8'h00,  8'hFF,  8'h00,  8'd1}   // R3
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_push(input logic [7:0] v);
        @(negedge clk);
        push_en = 1'b1;
        push_data = v;
        @(negedge clk);
        push_en = 1'b0;
    endtask

    task automatic do_change(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        chg_valid = 1'b1;
        chg_from = a;
        chg_to = b;
        while (!chg_ready) @(negedge clk);
        @(negedge clk);
        chg_valid = 1'b0;
    endtask

    task automatic do_pop(input logic [7:0] exp, input int hops, input bit exp_err,
                          input string tag);
        int n;
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        n = 0;
        chk({tag, " R8 chg_ready low during walk"}, int'(chg_ready), 0);
        while (!pop_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " data"}, int'(pop_data), int'(exp));
        chk({tag, " R4 latency"}, n, hops + 1);
        chk({tag, " R6 err"}, int'(pop_err), int'(exp_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", int'(q_empty), 1);
        chk("R1 full", int'(q_full), 0);
        chk("R1 valid", int'(pop_valid), 0);
        chk("R1 pop_ready", int'(pop_ready), 1);
        chk("R1 chg_ready", int'(chg_ready), 1);

        // R2 order with no mappings
        do_push(8'h12);
        do_push(8'h34);
        do_pop(8'h12, 0, 0, "R2 first");
        do_pop(8'h34, 0, 0, "R2 second");

        // R3: entry queued before the command is still redirected
        do_push(8'h90);
        do_change(8'h90, 8'h91);
        do_pop(8'h91, 1, 0, "R3 queued-before");

        // table walk
        for (int i = 0; i < 8; i++) begin
            do_change(VEC[i][39:32], VEC[i][31:24]);
            do_push(VEC[i][23:16]);
            do_pop(VEC[i][15:8], int'(VEC[i][7:0]), 0, $sformatf("vec%0d", i));
        end

        // R1: reset clears mappings
        do_reset();
        do_push(8'd10);
        do_pop(8'd10, 0, 0, "R1 table cleared");

        // R6: chain of exactly 8 hops 1->2->...->9
        for (int v = 1; v <= 8; v++) do_change(8'(v), 8'(v + 1));
        do_push(8'd1);
        do_pop(8'd9, 8, 0, "R6 eight hops");
        do_change(8'd9, 8'd10);
        do_push(8'd1);
        do_pop(8'd9, 8, 1, "R6 cap exceeded");
        do_change(8'h81, 8'h82);
        do_change(8'h82, 8'h81);
        do_push(8'h81);
        do_pop(8'h81, 8, 1, "R6 two-value cycle");

        // R8: command during a walk is ignored
        do_push(8'd1);
        do_push(8'h40);
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        chg_valid = 1'b1;
        chg_from = 8'h40;
        chg_to = 8'h41;
        chk("R8 pop_ready low", int'(pop_ready), 0);
        @(negedge clk);
        chg_valid = 1'b0;
        while (!pop_valid) @(negedge clk);
        do_pop(8'h40, 0, 0, "R8 ignored command");

        // R9: fill, overflow, drain, empty pop
        do_reset();
        for (int i = 0; i < 512; i++) do_push(8'(i * 7));
        @(negedge clk);
        chk("R9 full", int'(q_full), 1);
        chk("R9 not empty", int'(q_empty), 0);
        do_push(8'hAA);
        chk("R9 still full", int'(q_full), 1);
        for (int i = 0; i < 512; i++) do_pop(8'(i * 7), 0, 0, "R9 drain");
        @(negedge clk);
        chk("R9 empty after drain (extra push dropped)", int'(q_empty), 1);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R9 no valid on empty pop", int'(pop_valid), 0);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule